// File: doc/BRIEF.md
# Dual Queue Decode Merger

This block assembles one decode group from two instruction sources: a main queue of `MQ` entries and a separate branch queue of `BQ` entries. It fills up to `MQ+BQ` group slots one after another. At each slot it chooses between the branch-queue head and the main-queue head using a per-entry priority flag, a pending branch-follow condition, branch prediction state and a limit on how many unresolved branches an entry may sit behind. It also sends every chosen entry to an execution unit, based on the entry's class bits.

The block is a small state machine. A `start_i` pulse in `ST_IDLE` (transition IDLE→SCAN) begins a scan. In `ST_SCAN` exactly one slot is decided per clock. When no source can fill the next slot, or when every slot is full, the scan moves to `ST_DONE` (SCAN→DONE). `ST_DONE` lasts one cycle and then returns to `ST_IDLE` (DONE→IDLE). The caller holds the queue inputs stable from the start pulse until `done_o`. The group result stays on the outputs until the next accepted start.

Class bits (`*_cls_i`, five per entry): bit 0 integer (ALU, multiply, divide), bit 1 floating point, bit 2 load/store, bit 3 branch, bit 4 system register (special-register and condition-register moves, condition-register logic, system call, time-base read).

Top module: `dual_queue_merger`

## Requirements
- R1: After reset the block is in `ST_IDLE` with `grp_count_o`=0, `slot_valid_o`=0, `err_o`=0, `busy_o`=0 and `done_o`=0.
- R2: A `start_i` high in `ST_IDLE` clears the previous result and starts a scan. `busy_o` is high while scanning. `done_o` is high for exactly one cycle after the scan ends. `start_i` is ignored while `busy_o` or `done_o` is high.
- R3: The branch-queue entry at index k is taken first when all of these hold: k < min(`bq_count_i`, `BQ`), its priority flag is set or branch-follow is pending, and its branch counter is no greater than `spec_limit_i`.
- R4: Branch-follow starts from `follow_init_i`. Taking a branch-queue entry clears it. Taking a main-queue entry loads it from that entry's `mq_follow_i` bit.
- R5: While branch-follow is pending, no main-queue entry is taken. If the branch queue cannot fill the slot, the group ends.
- R6: A main-queue entry with `mq_is_br_i` set is taken only if its counter is no greater than `spec_limit_i` and it is either predicted or has neither `mq_cond_i` nor `mq_uncond_i` set. Otherwise the group ends at that slot.
- R7: Main-queue intake is at most min(`mq_count_i`, `MQ`, `rob_free_i`). Branch-queue intake is at most min(`bq_count_i`, `BQ`).
- R8: The unit code is the first class bit set, in this priority: integer=1, floating point=2, load/store=3, branch=4, system register=5.
- R9: An entry with no class bit set ends the group and is not counted. `err_o` is raised only when `unresolved_i` is low and no branch-unit entry is already in the group.
- R10: The group ends at the first slot that no source can fill. `grp_count_o` equals the number of set `slot_valid_o` bits, and these bits are contiguous from slot 0. Each slot reports its source in `slot_src_o` (1 = branch queue), its queue index and its unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a group scan |
| follow_init_i | input | 1 | Branch-follow state carried in from the previous group |
| unresolved_i | input | 1 | Unresolved branches exist in flight |
| spec_limit_i | input | CW | Highest branch counter an entry may carry |
| rob_free_i | input | RW | Free reorder-buffer entries |
| mq_count_i | input | $clog2(MQ+1) | Entries present in the main queue |
| mq_cls_i | input | MQ*5 | Class bits per main entry |
| mq_is_br_i | input | MQ | Main entry is a branch |
| mq_cond_i | input | MQ | Main entry is a conditional branch |
| mq_uncond_i | input | MQ | Main entry is an unconditional branch |
| mq_pred_i | input | MQ | Main entry's branch has a prediction |
| mq_follow_i | input | MQ | Main entry requests that a branch-queue entry follow it |
| mq_bcnt_i | input | MQ*CW | Branch counter per main entry |
| bq_count_i | input | $clog2(BQ+1) | Entries present in the branch queue |
| bq_prio_i | input | BQ | Priority flag per branch entry |
| bq_bcnt_i | input | BQ*CW | Branch counter per branch entry |
| bq_cls_i | input | BQ*5 | Class bits per branch entry |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| err_o | output | 1 | Unclassifiable entry with nothing to excuse it |
| grp_count_o | output | $clog2(MQ+BQ+1) | Slots filled |
| slot_valid_o | output | MQ+BQ | Slot filled |
| slot_src_o | output | MQ+BQ | Slot source, 1 = branch queue |
| slot_idx_o | output | (MQ+BQ)*IW | Queue index per slot |
| slot_unit_o | output | (MQ+BQ)*3 | Unit code per slot |

## Verification
Some properties are checked on every cycle: that valid bits stay contiguous and match the count, that a pending branch-follow never lets a main-queue entry through, that main intake never passes free reorder space, that the done pulse lasts one cycle, and that an error appears only as the scan ends. Other behaviours need the bench's scenarios against a reference model: the exact interleaving order, the branch acceptance rule, the unit priority, the choice between a silent stop and an error, and the ignoring of an extra start.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
    localparam int CLS_W   = 5;
    localparam int CLS_INT = 0;
    localparam int CLS_FP  = 1;
    localparam int CLS_LS  = 2;
    localparam int CLS_BR  = 3;
    localparam int CLS_SYS = 4;

    typedef enum logic [2:0] {
        UNIT_NONE = 3'd0,
        UNIT_INT  = 3'd1,
        UNIT_FP   = 3'd2,
        UNIT_LS   = 3'd3,
        UNIT_BR   = 3'd4,
        UNIT_SYS  = 3'd5
    } unit_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/dqm_unit_sort.sv
module dqm_unit_sort
    import dqm_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output unit_e            unit_o,
    output logic             known_o
);
    always_comb begin
        known_o = 1'b1;
        if (cls_i[CLS_INT])      unit_o = UNIT_INT;
        else if (cls_i[CLS_FP])  unit_o = UNIT_FP;
        else if (cls_i[CLS_LS])  unit_o = UNIT_LS;
        else if (cls_i[CLS_BR])  unit_o = UNIT_BR;
        else if (cls_i[CLS_SYS]) unit_o = UNIT_SYS;
        else begin
            unit_o  = UNIT_NONE;
            known_o = 1'b0;
        end
    end
endmodule

// File: rtl/dqm_pick.sv
module dqm_pick
    import dqm_pkg::*;
#(
    parameter int MQ = 4,
    parameter int BQ = 2,
    parameter int CW = 3,
    parameter int RW = 4,
    localparam int MCW = $clog2(MQ + 1),
    localparam int BCW = $clog2(BQ + 1)
) (
    input  logic [MCW-1:0]      mq_count_i,
    input  logic [RW-1:0]       rob_free_i,
    input  logic [BCW-1:0]      bq_count_i,
    input  logic [CW-1:0]       limit_i,
    input  logic [MCW-1:0]      j_i,
    input  logic [BCW-1:0]      k_i,
    input  logic                follow_i,
    input  logic [MQ*CLS_W-1:0] mq_cls_i,
    input  logic [MQ-1:0]       mq_is_br_i,
    input  logic [MQ-1:0]       mq_cond_i,
    input  logic [MQ-1:0]       mq_uncond_i,
    input  logic [MQ-1:0]       mq_pred_i,
    input  logic [MQ-1:0]       mq_follow_i,
    input  logic [MQ*CW-1:0]    mq_bcnt_i,
    input  logic [BQ-1:0]       bq_prio_i,
    input  logic [BQ*CW-1:0]    bq_bcnt_i,
    input  logic [BQ*CLS_W-1:0] bq_cls_i,
    output logic                take_bq_o,
    output logic                take_mq_o,
    output logic [CLS_W-1:0]    cls_o,
    output logic                fol_o
);
    int   mq_cap;
    int   bq_cap;
    int   jj;
    int   kk;
    logic bq_ok;
    logic mq_ok;

    always_comb begin
        // intake caps for each source
        mq_cap = int'(mq_count_i);
        if (mq_cap > MQ) mq_cap = MQ;
        if (int'(rob_free_i) < mq_cap) mq_cap = int'(rob_free_i);
        bq_cap = (int'(bq_count_i) > BQ) ? BQ : int'(bq_count_i);

        // safe head indexes (out-of-range heads are masked by the caps)
        jj = (int'(j_i) < MQ) ? int'(j_i) : 0;
        kk = (int'(k_i) < BQ) ? int'(k_i) : 0;

        bq_ok = (int'(k_i) < bq_cap)
             && (bq_prio_i[kk] || follow_i)
             && (bq_bcnt_i[kk*CW +: CW] <= limit_i);

        mq_ok = !mq_is_br_i[jj]
             || ((mq_bcnt_i[jj*CW +: CW] <= limit_i)
                 && ((!mq_cond_i[jj] && !mq_uncond_i[jj]) || mq_pred_i[jj]));

        take_bq_o = bq_ok;
        take_mq_o = !bq_ok && !follow_i && (int'(j_i) < mq_cap) && mq_ok;
        cls_o     = bq_ok ? bq_cls_i[kk*CLS_W +: CLS_W] : mq_cls_i[jj*CLS_W +: CLS_W];
        fol_o     = mq_follow_i[jj];
    end
endmodule

// File: rtl/dual_queue_merger.sv
module dual_queue_merger
    import dqm_pkg::*;
#(
    parameter int MQ = 4,
    parameter int BQ = 2,
    parameter int CW = 3,
    parameter int RW = 4,
    localparam int SLOTS = MQ + BQ,
    localparam int MCW   = $clog2(MQ + 1),
    localparam int BCW   = $clog2(BQ + 1),
    localparam int SW    = $clog2(SLOTS + 1),
    localparam int MIW   = (MQ > 1) ? $clog2(MQ) : 1,
    localparam int BIW   = (BQ > 1) ? $clog2(BQ) : 1,
    localparam int IW    = (MIW > BIW) ? MIW : BIW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                follow_init_i,
    input  logic                unresolved_i,
    input  logic [CW-1:0]       spec_limit_i,
    input  logic [RW-1:0]       rob_free_i,
    input  logic [MCW-1:0]      mq_count_i,
    input  logic [MQ*CLS_W-1:0] mq_cls_i,
    input  logic [MQ-1:0]       mq_is_br_i,
    input  logic [MQ-1:0]       mq_cond_i,
    input  logic [MQ-1:0]       mq_uncond_i,
    input  logic [MQ-1:0]       mq_pred_i,
    input  logic [MQ-1:0]       mq_follow_i,
    input  logic [MQ*CW-1:0]    mq_bcnt_i,
    input  logic [BCW-1:0]      bq_count_i,
    input  logic [BQ-1:0]       bq_prio_i,
    input  logic [BQ*CW-1:0]    bq_bcnt_i,
    input  logic [BQ*CLS_W-1:0] bq_cls_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [SW-1:0]       grp_count_o,
    output logic [SLOTS-1:0]    slot_valid_o,
    output logic [SLOTS-1:0]    slot_src_o,
    output logic [SLOTS*IW-1:0] slot_idx_o,
    output logic [SLOTS*3-1:0]  slot_unit_o
);
    state_e               state_q, state_d;
    logic [SW-1:0]        n_q;
    logic [MCW-1:0]       j_q;
    logic [BCW-1:0]       k_q;
    logic                 follow_q;
    logic                 brseen_q;
    logic                 err_q;
    logic [SLOTS-1:0]     valid_q;
    logic [SLOTS-1:0]     src_q;
    logic [SLOTS*IW-1:0]  idx_q;
    logic [SLOTS*3-1:0]   unit_q;

    logic                 take_bq, take_mq, fol_sel, known_sel;
    logic [CLS_W-1:0]     cls_sel;
    unit_e                unit_sel;
    logic                 any_take, fill, raise_err;

    dqm_pick #(.MQ(MQ), .BQ(BQ), .CW(CW), .RW(RW)) u_pick (
        .mq_count_i (mq_count_i),
        .rob_free_i (rob_free_i),
        .bq_count_i (bq_count_i),
        .limit_i    (spec_limit_i),
        .j_i        (j_q),
        .k_i        (k_q),
        .follow_i   (follow_q),
        .mq_cls_i   (mq_cls_i),
        .mq_is_br_i (mq_is_br_i),
        .mq_cond_i  (mq_cond_i),
        .mq_uncond_i(mq_uncond_i),
        .mq_pred_i  (mq_pred_i),
        .mq_follow_i(mq_follow_i),
        .mq_bcnt_i  (mq_bcnt_i),
        .bq_prio_i  (bq_prio_i),
        .bq_bcnt_i  (bq_bcnt_i),
        .bq_cls_i   (bq_cls_i),
        .take_bq_o  (take_bq),
        .take_mq_o  (take_mq),
        .cls_o      (cls_sel),
        .fol_o      (fol_sel)
    );

    dqm_unit_sort u_sort (
        .cls_i  (cls_sel),
        .unit_o (unit_sel),
        .known_o(known_sel)
    );

    assign any_take  = take_bq | take_mq;
    assign fill      = any_take & known_sel;
    assign raise_err = any_take & ~known_sel & ~(unresolved_i | brseen_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SCAN;
            ST_SCAN: if (!fill || (n_q == SW'(SLOTS - 1))) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o       = (state_q == ST_SCAN);
        done_o       = (state_q == ST_DONE);
        err_o        = err_q;
        grp_count_o  = n_q;
        slot_valid_o = valid_q;
        slot_src_o   = src_q;
        slot_idx_o   = idx_q;
        slot_unit_o  = unit_q;
    end

    // group datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q      <= '0;
            j_q      <= '0;
            k_q      <= '0;
            follow_q <= 1'b0;
            brseen_q <= 1'b0;
            err_q    <= 1'b0;
            valid_q  <= '0;
            src_q    <= '0;
            idx_q    <= '0;
            unit_q   <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            n_q      <= '0;
            j_q      <= '0;
            k_q      <= '0;
            follow_q <= follow_init_i;
            brseen_q <= 1'b0;
            err_q    <= 1'b0;
            valid_q  <= '0;
            src_q    <= '0;
            idx_q    <= '0;
            unit_q   <= '0;
        end else if (state_q == ST_SCAN) begin
            if (fill) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (s == int'(n_q)) begin
                        valid_q[s]          <= 1'b1;
                        src_q[s]            <= take_bq;
                        idx_q[s*IW +: IW]   <= take_bq ? IW'(k_q) : IW'(j_q);
                        unit_q[s*3 +: 3]    <= unit_sel;
                    end
                end
                n_q <= n_q + 1'b1;
                if (unit_sel == UNIT_BR) brseen_q <= 1'b1;
                if (take_bq) begin
                    k_q      <= k_q + 1'b1;
                    follow_q <= 1'b0;
                end else begin
                    j_q      <= j_q + 1'b1;
                    follow_q <= fol_sel;
                end
            end else if (raise_err) begin
                err_q <= 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_follow_blocks_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && follow_q) |-> !take_mq);

    assert_count_matches_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_valid_o) == int'(grp_count_o));

    assert_valid_contiguous_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid_o + 1'b1) & slot_valid_o) == '0);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_err_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (state_q == ST_DONE));

    assert_main_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (int'(j_q) <= int'(rob_free_i) && int'(j_q) <= MQ));
endmodule

// File: tb/dual_queue_merger_tb.sv
`timescale 1ns/1ps
module dual_queue_merger_tb;
    localparam int MQ = 4, BQ = 2, CW = 3, RW = 4;
    localparam int SLOTS = MQ + BQ;
    localparam int MCW = $clog2(MQ + 1), BCW = $clog2(BQ + 1), SW = $clog2(SLOTS + 1);
    localparam int IW = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic follow_init, unresolved;
    logic [CW-1:0] spec_limit;
    logic [RW-1:0] rob_free;
    logic [MCW-1:0] mq_count;
    logic [MQ*5-1:0] mq_cls;
    logic [MQ-1:0] mq_br, mq_cond, mq_unc, mq_pred, mq_fol;
    logic [MQ*CW-1:0] mq_bcnt;
    logic [BCW-1:0] bq_count;
    logic [BQ-1:0] bq_prio;
    logic [BQ*CW-1:0] bq_bcnt;
    logic [BQ*5-1:0] bq_cls;
    logic busy, done, err;
    logic [SW-1:0] cnt;
    logic [SLOTS-1:0] vld, src;
    logic [SLOTS*IW-1:0] idx;
    logic [SLOTS*3-1:0] unit;

    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    dual_queue_merger #(.MQ(MQ), .BQ(BQ), .CW(CW), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .follow_init_i(follow_init),
        .unresolved_i(unresolved), .spec_limit_i(spec_limit), .rob_free_i(rob_free),
        .mq_count_i(mq_count), .mq_cls_i(mq_cls), .mq_is_br_i(mq_br), .mq_cond_i(mq_cond),
        .mq_uncond_i(mq_unc), .mq_pred_i(mq_pred), .mq_follow_i(mq_fol), .mq_bcnt_i(mq_bcnt),
        .bq_count_i(bq_count), .bq_prio_i(bq_prio), .bq_bcnt_i(bq_bcnt), .bq_cls_i(bq_cls),
        .busy_o(busy), .done_o(done), .err_o(err), .grp_count_o(cnt),
        .slot_valid_o(vld), .slot_src_o(src), .slot_idx_o(idx), .slot_unit_o(unit)
    );

    typedef struct {
        string              tag;
        logic [SW-1:0]      cnt;
        logic [SLOTS-1:0]   vld;
        logic [SLOTS-1:0]   src;
        logic [SLOTS*IW-1:0] idx;
        logic [SLOTS*3-1:0] unit;
        logic               err;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic int unit_of(input logic [4:0] c);
        if (c[0]) return 1;
        if (c[1]) return 2;
        if (c[2]) return 3;
        if (c[3]) return 4;
        if (c[4]) return 5;
        return 0;
    endfunction

    // reference model built from the requirements
    task automatic model(output exp_t e);
        int j = 0, k = 0, n = 0, mcap, bcap, u;
        bit fol = follow_init, brs = 0, tb, tm;
        logic [4:0] c;
        e.cnt = '0; e.vld = '0; e.src = '0; e.idx = '0; e.unit = '0; e.err = 1'b0;
        mcap = int'(mq_count); if (mcap > MQ) mcap = MQ;
        if (int'(rob_free) < mcap) mcap = int'(rob_free);
        bcap = int'(bq_count); if (bcap > BQ) bcap = BQ;
        while (n < SLOTS) begin
            tb = 0; tm = 0;
            if (k < bcap && (bq_prio[k] || fol) && bq_bcnt[k*CW +: CW] <= spec_limit) tb = 1;
            if (!tb && !fol && j < mcap)
                tm = !mq_br[j] || (mq_bcnt[j*CW +: CW] <= spec_limit &&
                                   ((!mq_cond[j] && !mq_unc[j]) || mq_pred[j]));
            if (!tb && !tm) break;
            c = tb ? bq_cls[k*5 +: 5] : mq_cls[j*5 +: 5];
            u = unit_of(c);
            if (u == 0) begin
                if (!(unresolved || brs)) e.err = 1'b1;
                break;
            end
            e.vld[n] = 1'b1;
            e.src[n] = tb;
            e.idx[n*IW +: IW] = tb ? IW'(k) : IW'(j);
            e.unit[n*3 +: 3] = 3'(u);
            if (u == 4) brs = 1;
            if (tb) begin k++; fol = 0; end
            else begin fol = mq_fol[j]; j++; end
            n++;
        end
        e.cnt = SW'(n);
    endtask

    task automatic clear_inputs();
        follow_init = 0; unresolved = 0; spec_limit = 3'd2; rob_free = 4'd15;
        mq_count = '0; mq_cls = '0; mq_br = '0; mq_cond = '0; mq_unc = '0;
        mq_pred = '0; mq_fol = '0; mq_bcnt = '0;
        bq_count = '0; bq_prio = '0; bq_bcnt = '0; bq_cls = '0;
    endtask

    task automatic set_mq(input int i, input logic [4:0] c, input bit br, input bit cd,
                          input bit uc, input bit pr, input bit fl, input logic [CW-1:0] bc);
        mq_cls[i*5 +: 5] = c; mq_br[i] = br; mq_cond[i] = cd; mq_unc[i] = uc;
        mq_pred[i] = pr; mq_fol[i] = fl; mq_bcnt[i*CW +: CW] = bc;
    endtask

    task automatic set_bq(input int i, input bit pr, input logic [CW-1:0] bc, input logic [4:0] c);
        bq_prio[i] = pr; bq_bcnt[i*CW +: CW] = bc; bq_cls[i*5 +: 5] = c;
    endtask

    // driver: predict, push, start, wait for completion
    task automatic run(input string tag, input bit extra_start);
        exp_t e;
        model(e);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2", {tag, " busy"}, 64'(busy), 64'd1);
        if (extra_start) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cnt == e.cnt,   e.tag, "count", 64'(cnt),  64'(e.cnt));
                chk(vld == e.vld,   e.tag, "valid", 64'(vld),  64'(e.vld));
                chk(src == e.src,   e.tag, "src",   64'(src),  64'(e.src));
                chk(idx == e.idx,   e.tag, "idx",   64'(idx),  64'(e.idx));
                chk(unit == e.unit, e.tag, "unit",  64'(unit), 64'(e.unit));
                chk(err == e.err,   e.tag, "err",   64'(err),  64'(e.err));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    localparam logic [4:0] C_INT = 5'b00001, C_BR = 5'b01000, C_NONE = 5'b00000;

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cnt == '0, "R1", "count", 64'(cnt), 64'd0);
        chk(vld == '0, "R1", "valid", 64'(vld), 64'd0);
        chk(err == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "flags",
            64'({err, done, busy}), 64'd0);

        // R8 unit priority over multi-bit classes
        clear_inputs(); mq_count = 3'd4;
        set_mq(0, 5'b10001, 0,0,0,0,0, 0); set_mq(1, 5'b10110, 0,0,0,0,0, 0);
        set_mq(2, 5'b11100, 0,0,0,0,0, 0); set_mq(3, 5'b10000, 0,0,0,0,0, 0);
        run("R8", 0);

        // R3 priority branch entries go first
        clear_inputs(); mq_count = 3'd2; bq_count = 2'd2;
        set_mq(0, C_INT, 0,0,0,0,0, 0); set_mq(1, 5'b00010, 0,0,0,0,0, 0);
        set_bq(0, 1, 0, C_BR); set_bq(1, 1, 1, C_BR);
        run("R3", 0);

        // R3 branch head over the counter limit is skipped
        clear_inputs(); mq_count = 3'd2; bq_count = 2'd1;
        set_mq(0, C_INT, 0,0,0,0,0, 0); set_mq(1, C_INT, 0,0,0,0,0, 0);
        set_bq(0, 1, 3'd3, C_BR);
        run("R3_limit", 0);

        // R5 carried-in follow with empty branch queue
        clear_inputs(); follow_init = 1; mq_count = 3'd3;
        set_mq(0, C_INT, 0,0,0,0,0, 0);
        run("R5_init", 0);

        // R4 follow loaded from a main entry
        clear_inputs(); mq_count = 3'd2; bq_count = 2'd1;
        set_mq(0, C_INT, 0,0,0,0,1, 0); set_mq(1, C_INT, 0,0,0,0,0, 0);
        set_bq(0, 0, 0, C_BR);
        run("R4", 0);

        // R5 follow pending but branch head over limit
        clear_inputs(); mq_count = 3'd2; bq_count = 2'd1;
        set_mq(0, C_INT, 0,0,0,0,1, 0); set_mq(1, C_INT, 0,0,0,0,0, 0);
        set_bq(0, 0, 3'd3, C_BR);
        run("R5_stop", 0);

        // R6 unpredicted conditional branch stops
        clear_inputs(); mq_count = 3'd3;
        set_mq(0, C_INT, 0,0,0,0,0, 0); set_mq(1, C_BR, 1,1,0,0,0, 1); set_mq(2, C_INT, 0,0,0,0,0, 0);
        run("R6_unpred", 0);
        // R6 predicted
        mq_pred[1] = 1'b1;
        run("R6_pred", 0);
        // R6 indirect branch, neither kind, no prediction
        mq_pred[1] = 1'b0; mq_cond[1] = 1'b0;
        run("R6_other", 0);
        // R6 predicted unconditional over the limit
        mq_unc[1] = 1'b1; mq_pred[1] = 1'b1; mq_bcnt[1*CW +: CW] = 3'd3;
        run("R6_limit", 0);

        // R7 reorder space caps main intake
        clear_inputs(); mq_count = 3'd4; rob_free = 4'd2;
        for (int i = 0; i < MQ; i++) set_mq(i, C_INT, 0,0,0,0,0, 0);
        run("R7_rob", 0);
        // R7 queue counts cap intake, branch count above depth
        rob_free = 4'd15; mq_count = 3'd3; bq_count = 2'd3;
        set_bq(0, 1, 0, C_BR); set_bq(1, 1, 0, C_BR);
        run("R7_count", 0);

        // R9 unclassifiable raises error
        clear_inputs(); mq_count = 3'd3;
        set_mq(0, C_INT, 0,0,0,0,0, 0); set_mq(1, C_NONE, 0,0,0,0,0, 0); set_mq(2, C_INT, 0,0,0,0,0, 0);
        run("R9_err", 0);
        // R9 excused by unresolved branches
        unresolved = 1;
        run("R9_unres", 0);
        // R9 excused by a branch already in the group
        unresolved = 0; bq_count = 2'd1; set_bq(0, 1, 0, C_BR);
        set_mq(0, C_NONE, 0,0,0,0,0, 0);
        run("R9_brgrp", 0);

        // R10 fully packed group
        clear_inputs(); mq_count = 3'd4; bq_count = 2'd2;
        for (int i = 0; i < MQ; i++) set_mq(i, 5'b00100, 0,0,0,0,0, 0);
        set_bq(0, 1, 0, C_BR); set_bq(1, 0, 0, C_BR);
        mq_fol[0] = 1'b1;
        run("R10_full", 0);

        // R2 start during a scan is ignored
        clear_inputs(); mq_count = 3'd4;
        for (int i = 0; i < MQ; i++) set_mq(i, C_INT, 0,0,0,0,0, 0);
        run("R2_ignore", 1);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R2", "no second scan", 64'(exp_q.size()), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule